// File: doc/BRIEF.md
# Direct-Mapped Line Store With Hit Detection

This block is the storage and tag-compare half of a small direct-mapped cache. It keeps 16 lines of four 16-bit words. Each line has a valid flag and one RAM row that packs the stored tag with the four data words. A 16-bit processor address is decoded into three fields: a tag, a line index and a word offset. The block compares the stored tag and valid flag of the indexed line against the address and raises a miss flag when the line does not hold that address.

A separate controller, not part of this block, sequences the accesses and presents a numeric state code. Four word registers stage one line at a time. By default they reload from the indexed row on every cycle. In the refill state the word chosen by the controller's counter takes data from the off-chip bus instead. In the merge state the word chosen by the address offset takes the processor's write data. In the write-back states the staged words, together with the address tag, are written back into the row as a single unit. The word named by the offset is always presented to the processor.

The controller state codes used are: 2 for refill-capture, 3 for refill-write, 4 for merge, 5 for write, and 8 for done. Every other code acts as an idle or read state.

Top module: `line_store`

## Requirements
- R1: Address bits [1:0] select the word, bits [5:2] select one of 16 lines, and bits [15:6] form the 10-bit tag.
- R2: `miss` is 1 when the valid flag of the indexed line is 0, or when the flag is 1 and the row's stored tag differs from address bits [15:6]. Otherwise it is 0.
- R3: When `ram_rd` is 0, the next rising edge writes the indexed row. The row's tag field takes address bits [15:6] and its four words take the current staging registers. A row read is combinational from the current index.
- R4: Reset clears every valid flag. Code 8 on `ctl_state` sets the valid flag of the indexed line at the next edge. No other code changes any valid flag.
- R5: `ram_rd` is 0 exactly when `ctl_state` is 3, or when `ctl_state` is 5 and `miss` is 0. In every other case it is 1.
- R6: In every state other than 2 and 4, all four staging registers load the words of the indexed row at each edge.
- R7: In state 4, the staging register chosen by address bits [1:0] loads `wr_data`. The other three registers load from the row.
- R8: In state 2, the staging register chosen by `word_cnt` loads `bus_data`. The other three registers load from the row.
- R9: `rd_word` is the staging register selected by address bits [1:0]. Reset sets all staging registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address |
| wr_data | input | 16 | Processor write data |
| bus_data | input | 16 | Low word of the off-chip data bus |
| ctl_state | input | 4 | State code from the external controller |
| word_cnt | input | 2 | Refill word counter from the controller |
| miss | output | 1 | Indexed line does not hold the address |
| ram_rd | output | 1 | 1 = row read, 0 = row written at the next edge |
| rd_word | output | 16 | Selected staged word to the processor |

## Verification
Two things happen at the same edge in states 3 and 5: the staged line is written back into the row, and the staging registers reload from that same row. This means the registers capture the row as it was before the write. The bench triggers this in every refill step and in every write hit. On the following cycle the reference model predicts which values `rd_word` shows, and the row contents it predicts are compared again once the next reload brings them back out. A write miss is also driven: the line's old valid flag stays set while the new tag is already in the row, so the same edges test tag replacement and hit detection together.

// File: rtl/line_store.sv
module line_store #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int ST_W   = 4,
  localparam int IDX_W  = $clog2(LINES),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int DATA_W = WORDS * WORD_W,
  localparam int ROW_W  = TAG_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WORD_W-1:0] bus_data,
  input  logic [ST_W-1:0]   ctl_state,
  input  logic [OFF_W-1:0]  word_cnt,
  output logic              miss,
  output logic              ram_rd,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [ST_W-1:0] ST_REFILL = ST_W'(2);
  localparam logic [ST_W-1:0] ST_FILLWR = ST_W'(3);
  localparam logic [ST_W-1:0] ST_MERGE  = ST_W'(4);
  localparam logic [ST_W-1:0] ST_WRITE  = ST_W'(5);
  localparam logic [ST_W-1:0] ST_DONE   = ST_W'(8);

  logic [LINES-1:0]              valid_q;
  logic [ROW_W-1:0]              rows_q [LINES];
  logic [WORDS-1:0][WORD_W-1:0]  blk_q;
  logic [ROW_W-1:0]              row_rd, row_wr;

  wire [IDX_W-1:0] idx = addr[OFF_W +: IDX_W];
  wire [OFF_W-1:0] off = addr[OFF_W-1:0];
  wire [TAG_W-1:0] tag = addr[ADDR_W-1 -: TAG_W];

  assign row_rd  = rows_q[idx];
  assign row_wr  = {tag, blk_q};
  assign miss    = !valid_q[idx] || (row_rd[ROW_W-1 -: TAG_W] != tag);
  assign ram_rd  = !(ctl_state == ST_FILLWR || (ctl_state == ST_WRITE && !miss));
  assign rd_word = blk_q[off];

  always_ff @(posedge clk)
    if (!ram_rd) rows_q[idx] <= row_wr;

  always_ff @(posedge clk)
    if (rst) valid_q <= '0;
    else if (ctl_state == ST_DONE) valid_q[idx] <= 1'b1;

  always_ff @(posedge clk)
    for (int w = 0; w < WORDS; w++)
      if (rst)
        blk_q[w] <= '0;
      else if (ctl_state == ST_MERGE && off == OFF_W'(w))
        blk_q[w] <= wr_data;
      else if (ctl_state == ST_REFILL && word_cnt == OFF_W'(w))
        blk_q[w] <= bus_data;
      else
        blk_q[w] <= row_rd[w*WORD_W +: WORD_W];

  a_r4_valid_set: assert property (@(posedge clk) disable iff (rst)
    ctl_state == ST_DONE |=> valid_q[$past(idx)]);
  a_r4_valid_hold: assert property (@(posedge clk) disable iff (rst)
    ctl_state != ST_DONE |=> $stable(valid_q));
  a_r3_row_write: assert property (@(posedge clk) disable iff (rst)
    !ram_rd |=> rows_q[$past(idx)] === $past(row_wr));
  a_r5_write_states: assert property (@(posedge clk) disable iff (rst)
    !ram_rd |-> (ctl_state == ST_FILLWR || ctl_state == ST_WRITE));
  a_r7_merge: assert property (@(posedge clk) disable iff (rst)
    ctl_state == ST_MERGE |=> blk_q[$past(off)] == $past(wr_data));
  a_r8_refill: assert property (@(posedge clk) disable iff (rst)
    ctl_state == ST_REFILL |=> blk_q[$past(word_cnt)] == $past(bus_data));
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (ctl_state != ST_REFILL && ctl_state != ST_MERGE) |=> blk_q === $past(row_rd[DATA_W-1:0]));
endmodule

// File: tb/line_store_test.sv
module line_store_test;
  logic clk = 0, rst = 1;
  logic [15:0] addr = 0, wr_data = 0, bus_data = 0;
  logic [3:0] ctl_state = 0;
  logic [1:0] word_cnt = 0;
  logic miss, ram_rd;
  logic [15:0] rd_word;
  int checks = 0, errors = 0;

  line_store uut (.clk, .rst, .addr, .wr_data, .bus_data, .ctl_state, .word_cnt,
                  .miss, .ram_rd, .rd_word);

  always #10 clk = ~clk;

  bit          mv [16];
  bit          mkt[16];
  logic [9:0]  mt [16];
  logic [15:0] md [16][4];
  bit          mk [16][4];
  logic [15:0] mb [4];
  bit          mbk[4];

  task automatic chk(input bit ok, input string what, input logic [15:0] act, exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // R1: fields are decoded in the model as a[1:0], a[5:2], a[15:6]
  task automatic step(input int st, input logic [15:0] a, input logic [15:0] wd,
                      input logic [15:0] bd, input int cnt);
    int i, o;
    bit hit, erd;
    logic [15:0] nb[4];
    bit nk[4];
    addr = a; ctl_state = 4'(st); wr_data = wd; bus_data = bd; word_cnt = 2'(cnt);
    #2;
    i = int'(a[5:2]); o = int'(a[1:0]);
    hit = mv[i] && mkt[i] && mt[i] == a[15:6];
    erd = !(st == 3 || (st == 5 && hit));
    chk(miss === !hit, "R2 miss", {15'b0, miss}, {15'b0, !hit});
    chk(ram_rd === erd, "R5 ram_rd", {15'b0, ram_rd}, {15'b0, erd});
    if (mbk[o]) chk(rd_word === mb[o], "R9 rd_word", rd_word, mb[o]);
    @(posedge clk);
    for (int w = 0; w < 4; w++) begin
      nb[w] = md[i][w]; nk[w] = mk[i][w];          // R6 default reload
      if (st == 4 && w == o) begin nb[w] = wd; nk[w] = 1; end  // R7
      if (st == 2 && w == cnt) begin nb[w] = bd; nk[w] = 1; end // R8
    end
    if (!erd) begin                                 // R3 row write
      mt[i] = a[15:6]; mkt[i] = 1;
      for (int w = 0; w < 4; w++) begin md[i][w] = mb[w]; mk[i][w] = mbk[w]; end
    end
    for (int w = 0; w < 4; w++) begin mb[w] = nb[w]; mbk[w] = nk[w]; end
    if (st == 8) mv[i] = 1;                         // R4 valid set
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; ctl_state = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) mv[i] = 0;         // R4 valid clear
    for (int w = 0; w < 4; w++) begin mb[w] = 0; mbk[w] = 1; end
    rst = 0;
  endtask

  task automatic refill(input logic [15:0] a, input logic [15:0] seed);
    for (int k = 0; k < 4; k++) begin
      step(2, a, 0, seed + 16'(k * 17), k);
      step(3, a, 0, 0, 0);
    end
  endtask

  task automatic read_line(input logic [15:0] a);
    for (int k = 0; k < 4; k++) step(0, {a[15:2], 2'(k)}, 0, 0, 0);
    step(0, a, 0, 0, 0);
  endtask

  localparam logic [15:0] LA = {10'h2A5, 4'd3, 2'd0};
  localparam logic [15:0] LB = {10'h0F1, 4'd3, 2'd0};
  localparam logic [15:0] LC = {10'h133, 4'd12, 2'd0};

  initial begin
    for (int i = 0; i < 16; i++) begin
      mkt[i] = 0;
      for (int w = 0; w < 4; w++) mk[i][w] = 0;
    end
    @(negedge clk);
    do_reset();
    // reset state: every line misses, rd_word zero (R9)
    step(0, LA, 0, 0, 0);
    step(0, LC, 0, 0, 0);
    // refill line A at index 3 (R8, R3), then mark valid (R4)
    step(5, LA, 16'h1111, 0, 0);
    refill(LA, 16'hA000);
    step(8, LA, 0, 0, 0);
    read_line(LA);
    // write hit at offset 2 (R7 then R3 via state 5)
    step(4, LA | 16'd2, 16'hBEEF, 0, 0);
    step(5, LA | 16'd2, 16'hBEEF, 0, 0);
    step(8, LA | 16'd2, 0, 0, 0);
    read_line(LA);
    // write miss on same index with a different tag: R2 miss, then replace tag
    step(5, LB | 16'd1, 16'h5A5A, 0, 0);
    refill(LB, 16'hC000);
    step(4, LB | 16'd1, 16'h5A5A, 0, 0);
    step(5, LB | 16'd1, 16'h5A5A, 0, 0);
    step(8, LB | 16'd1, 0, 0, 0);
    read_line(LB);
    step(0, LA, 0, 0, 0);                           // old tag now misses (R2)
    // another index, refill counter out of order (R8)
    step(2, LC, 0, 16'h7001, 3);
    step(3, LC, 0, 0, 0);
    step(2, LC, 0, 16'h7002, 0);
    step(3, LC, 0, 0, 0);
    step(8, LC, 0, 0, 0);
    read_line(LC);
    // state 5 with miss must not write (R5): different tag, index 12
    step(5, {10'h001, 4'd12, 2'd0}, 16'hDEAD, 0, 0);
    read_line(LC);
    // reset clears valid flags again (R4)
    do_reset();
    step(0, LB, 0, 0, 0);
    step(0, LC, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule